// File: doc/BRIEF.md
# Center-aligned hybrid pulse-width modulator

This block turns a 6-bit envelope amplitude code into one output pulse per frame. The pulse is placed symmetrically about the middle of the frame. A frame is made of 128 equal phase slots. Each slot is one tick of a fast clock, and the slots stand in for the taps of a multi-phase delay line. The most significant bit of the slot counter tells the first half of the frame from the second. One 64-way tap selector is shared between the two halves. In the first half it places the rising edge, and in the second half it places the falling edge.

The code is taken in once per frame, at the frame boundary. A new amplitude can be presented at any time, but the pulse already in flight keeps its shape. A one-clock strobe marks the first slot of every frame, so the source of the envelope samples can stay in step with the modulator.

Slot numbering used below: the cycle in which `frame_start` is high is slot 0, and the following cycles are slots 1 to 127.

Top module: `cpwm_center`

## Requirements
- R1: A frame lasts exactly 128 clocks. `frame_start` is high in slot 0 of each frame and low in every other slot.
- R2: When the captured code is 0, `pwm_out` stays low for the whole frame.
- R3: When the captured code w is between 1 and 63, `pwm_out` is high exactly in slots 64−w through 63+w. The pulse is therefore 2·w clocks wide.
- R4: The rising-edge slot and the falling-edge slot of every pulse add up to 128, so the pulse is centred on slot 64.
- R5: The code is sampled only on the clock edge that ends slot 0. Values that `code_in` takes in slots 1 to 127 do not change the pulse of the current frame.
- R6: While `rst` is high, `pwm_out` is low and the block is held at slot 0 with a captured code of 0. The first cycle after `rst` falls is slot 0.
- R7: A rising edge of `pwm_out` occurs only in slots 1 to 63. A falling edge occurs only in slots 64 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one period is one phase slot |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 6 | Envelope amplitude code |
| pwm_out | output | 1 | Center-aligned pulse output |
| frame_start | output | 1 | High for one clock in slot 0 of each frame |

## Verification
Two things happen in the same cycle at slot 0: the strobe marks the new frame, and the next code is loaded. The bench presents the intended code only in the slot 0 cycle and drives unrelated codes in every other slot. A frame whose width is not 2·w, or whose edges do not add up to 128, shows that the capture point was wrong. A reset is also applied while a pulse is high, to check that an edge and a reset arriving together leave the output low and the next cycle at slot 0.

// File: rtl/cpwm_center.sv
module cpwm_center #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              pwm_out,
  output logic              frame_start
);
  localparam int SLOT_W = CODE_W + 1;

  logic [SLOT_W-1:0] slot, slot_nx;
  logic [CODE_W-1:0] code_q, code_nx, tap_sel, tap_nx;
  logic              half_nx, on_nx;

  assign slot_nx = slot + SLOT_W'(1);
  assign half_nx = slot_nx[SLOT_W-1];
  assign tap_nx  = slot_nx[CODE_W-1:0];
  assign code_nx = (slot == '0) ? code_in : code_q;

  assign tap_sel = half_nx ? code_nx : (CODE_W'(0) - code_nx);
  assign on_nx   = (code_nx != '0) && (half_nx ? (tap_nx < tap_sel) : (tap_nx >= tap_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      code_q  <= '0;
      pwm_out <= 1'b0;
    end else begin
      slot    <= slot_nx;
      code_q  <= code_nx;
      pwm_out <= on_nx;
    end
  end

  assign frame_start = (slot == '0);
endmodule

// File: rtl/cpwm_center_chk.sv
module cpwm_center_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_in,
  input logic              pwm_out,
  input logic              frame_start
);
  localparam int SLOT_W = CODE_W + 1;
  localparam int HALF   = 1 << CODE_W;

  logic [SLOT_W-1:0] c_slot;
  logic [CODE_W-1:0] c_code;
  logic              rst_d = 1'b0;
  logic              c_on;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      c_slot <= '0;
      c_code <= '0;
    end else begin
      c_slot <= c_slot + SLOT_W'(1);
      if (c_slot == '0) c_code <= code_in;
    end
  end

  assign c_on = (c_code != '0) && (int'(c_slot) >= HALF - int'(c_code))
                && (int'(c_slot) < HALF + int'(c_code));

  AST_FRAME_STROBE: assert property (@(posedge clk) disable iff (rst) frame_start == (c_slot == '0)); // R1
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst) (c_code == '0) |-> !pwm_out); // R2
  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (rst) pwm_out == c_on); // R3
  AST_RISE_FIRST_HALF: assert property (@(posedge clk) disable iff (rst) $rose(pwm_out) |-> (int'(c_slot) < HALF && c_slot != '0)); // R7
  AST_FALL_SECOND_HALF: assert property (@(posedge clk) disable iff (rst) $fell(pwm_out) |-> (int'(c_slot) >= HALF)); // R7

  always @(posedge clk) begin
    if (rst_d) AST_RESET_STATE: assert (!pwm_out && frame_start); // R6
  end
endmodule

bind cpwm_center cpwm_center_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .pwm_out(pwm_out), .frame_start(frame_start)
);

// File: tb/cpwm_center_test.sv
module cpwm_center_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] code_in = '0;
  logic pwm_out, frame_start;

  int total = 0, bad = 0;
  int ref_slot = 0, ref_code = 0;
  int rise_at = -1, fall_at = -1;
  bit have_frame = 0, last_rst = 0, done = 0;
  logic prev_pwm = 1'b0;
  int next_code = 0;

  cpwm_center uut (.clk(clk), .rst(rst), .code_in(code_in), .pwm_out(pwm_out), .frame_start(frame_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic judge_frame(int w);
    if (w == 0) begin
      check("R2", "rise slot for code 0", rise_at, -1);
      check("R2", "fall slot for code 0", fall_at, -1);
    end else begin
      check("R3", "pulse width", fall_at - rise_at, 2 * w);
      check("R4", "edge sum", rise_at + fall_at, 128);
      check("R7", "rise in first half", int'(rise_at >= 1 && rise_at < 64), 1);
      check("R7", "fall in second half", int'(fall_at >= 64 && fall_at < 128), 1);
    end
  endtask

  task automatic step(logic r, logic [5:0] c);
    int exp_pwm;
    @(negedge clk);
    exp_pwm = (ref_code != 0 && ref_slot >= 64 - ref_code && ref_slot < 64 + ref_code) ? 1 : 0;
    check("R1", "frame_start", int'(frame_start), int'(ref_slot == 0));
    check(ref_code == 0 ? "R2" : "R3", "pwm_out", int'(pwm_out), exp_pwm);
    if (last_rst) begin
      check("R6", "pwm after reset", int'(pwm_out), 0);
      check("R6", "strobe after reset", int'(frame_start), 1);
    end
    if (ref_slot == 0) begin
      if (have_frame) judge_frame(ref_code);
      rise_at = -1; fall_at = -1; have_frame = 0;
    end else begin
      if (pwm_out && !prev_pwm) rise_at = ref_slot;
      if (!pwm_out && prev_pwm) fall_at = ref_slot;
    end
    if (ref_slot == 127) have_frame = 1;
    prev_pwm = pwm_out;
    rst = r; code_in = c; last_rst = r;
    if (r) begin
      ref_slot = 0; ref_code = 0; have_frame = 0; rise_at = -1; fall_at = -1;
    end else begin
      if (ref_slot == 0) ref_code = int'(c);
      ref_slot = (ref_slot + 1) % 128;
    end
  endtask

  // R5: intended code only in slot 0, scrambled codes in every other slot
  task automatic run_cycle(int want);
    logic [5:0] c;
    c = (ref_slot == 0) ? 6'(want) : 6'((want * 37 + ref_slot * 11 + 5) & 63);
    step(1'b0, c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 6'd0);
    for (int f = 0; f < 66; f++) begin
      next_code = f % 64;
      for (int s = 0; s < 128; s++) run_cycle(next_code);
    end
    // R6: reset in the middle of a wide pulse
    for (int s = 0; s < 60; s++) run_cycle(40);
    step(1'b1, 6'd17);
    step(1'b1, 6'd17);
    for (int s = 0; s < 128; s++) run_cycle(63);
    for (int s = 0; s < 128; s++) run_cycle(1);
    for (int s = 0; s < 129; s++) run_cycle(0);
    summary();
  end
endmodule